// File: doc/BRIEF.md
# Serial Receive Path with Buffered Line Status

This block is the receive half of an asynchronous serial port. A 16x oversampling tick paces a small state machine that finds a start bit, samples the data bits least significant first, optionally checks a parity bit and samples the stop bit. Each finished character goes into a 16-entry receive queue together with a one-bit parity-error tag.

The host sees the character at the head of the queue on `rd_data` at all times. A one-cycle `rd_data_strobe` removes that character. Three status flags sit beside the data. The ready flag follows queue occupancy. The overrun flag and the parity-error flag are sticky, and a one-cycle `rd_status_strobe` clears them. The parity-error flag describes the character now at the head of the queue, so the host reads the status before it removes the data.

The `rxd` input must already be synchronised to `clk`. The line settings must not change while a frame is being received.

Top module: `uart_rx_lsr`

## Requirements
- R1: After a synchronous active-low reset, `st_data_ready`, `st_overrun` and `st_parity_err` are 0 and `fifo_level` is 0.
- R2: A frame is a low start bit, then the data bits least significant first, then an optional parity bit, then a stop bit. Each bit lasts 16 ticks. The start bit is confirmed by a low sample 8 ticks after the falling edge is seen, and every later bit is sampled 16 ticks after the one before it. Characters leave the queue in arrival order: `rd_data` shows the oldest one, and `rd_data_strobe` removes it.
- R3: `cfg_len` selects the character length: 0 is 5 bits, 1 is 6, 2 is 7 and 3 is 8. A short character is placed right-aligned in `rd_data`, and the unused upper bits read 0.
- R4: `st_data_ready` is 1 while the queue holds at least one character, and 0 once the last one has been removed.
- R5: When a character completes while the queue already holds 16 entries, that character is discarded. The queued entries and `fifo_level` do not change.
- R6: `st_overrun` is set in the cycle after such a discarded completion, and it stays set until a status read. If a status read happens in the same cycle as a new overrun, the flag stays set.
- R7: When `cfg_par_en` is 1, a parity bit follows the data bits. `cfg_par_sel` gives the expected value of that bit: 0 makes the count of ones across data and parity bit odd, 1 makes it even, 2 expects a 1 and 3 expects a 0. A mismatch tags the character. When `cfg_par_en` is 0, no parity bit is sent and no character is tagged.
- R8: `st_parity_err` is set when a tagged character becomes the head of the queue, either by being written into an empty queue or by the removal of the entry ahead of it. A tagged character that is queued behind others does not set the flag.
- R9: A status read clears `st_parity_err`, unless a tagged character reaches the head in that same cycle.
- R10: If `rxd` goes low but is high again at the 8-tick check, the frame is dropped and nothing is queued.
- R11: `fifo_level` equals the number of characters held in the queue, from 0 to 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 1 | Synchronised serial receive line; idles high |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| cfg_len | input | 2 | Character length code: 0 to 3 selects 5 to 8 bits |
| cfg_par_en | input | 1 | 1 means a parity bit follows the data bits |
| cfg_par_sel | input | 2 | Parity mode: 0 odd, 1 even, 2 forced 1, 3 forced 0 |
| rd_data_strobe | input | 1 | Host data read; removes the head character |
| rd_status_strobe | input | 1 | Host status read; clears the overrun and parity-error flags |
| rd_data | output | 8 | Head character, right-aligned |
| st_data_ready | output | 1 | At least one character is queued |
| st_overrun | output | 1 | Sticky overrun flag |
| st_parity_err | output | 1 | Sticky parity-error flag for the head character |
| fifo_level | output | 5 | Number of queued characters |

## Verification
The assertions assume that `baud_tick` is a single-cycle pulse, that `rxd` is synchronous to `clk`, and that the line settings stay constant for the whole of a frame. The stimulus changes `rxd` and the settings only on falling clock edges and only between frames. Each bit is held for exactly 64 clocks, which is 16 ticks of a divide-by-4 tick generator, so every sample lands well inside its bit. Strobes are single-cycle pulses, except in the overrun case. There the status strobe is held high on purpose across the frame that overflows the queue, so that a set and a clear fall in the same cycle.

// File: rtl/uart_rx_pkg.sv
// Package: shared types for the serial receive path.
// Assumes a character width of at most 8 bits.
package uart_rx_pkg;
    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_t;

    typedef struct packed {
        logic              perr;
        logic [CHAR_W-1:0] data;
    } rx_entry_t;
endpackage

// File: rtl/uart_rx_deser.sv
// Module: uart_rx_deser
// Turns oversampled serial frames into characters with a parity-error tag.
// Emits a one-cycle char_valid pulse once the stop bit has been sampled.
// Assumes rxd is synchronous to clk and that the cfg_* inputs are stable
// for the whole of a frame.
module uart_rx_deser
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              baud_tick,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic [1:0]        cfg_par_sel,
    output logic              char_valid,
    output rx_entry_t         char_out
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    rx_state_t         state;
    logic [CW-1:0]     tcnt;
    logic [3:0]        bidx;
    logic [CHAR_W-1:0] shreg;
    logic              par_acc;
    logic              perr_r;
    logic [3:0]        nbits;
    logic              exp_par;

    // Character length in bits, from the length code.
    assign nbits = {2'b00, cfg_len} + 4'd5;

    // Expected value of the parity bit for the selected mode.
    always_comb begin
        case (cfg_par_sel)
            2'd0:    exp_par = ~par_acc;
            2'd1:    exp_par = par_acc;
            2'd2:    exp_par = 1'b1;
            default: exp_par = 1'b0;
        endcase
    end

    // Frame state machine: start check, data shift, parity check, stop sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= RX_IDLE;
            tcnt       <= '0;
            bidx       <= '0;
            shreg      <= '0;
            par_acc    <= 1'b0;
            perr_r     <= 1'b0;
            char_valid <= 1'b0;
            char_out   <= '0;
        end else begin
            char_valid <= 1'b0;
            if (baud_tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!rxd) begin
                            state <= RX_START;
                            tcnt  <= '0;
                        end
                    end
                    RX_START: begin
                        if (tcnt == MID) begin
                            tcnt    <= '0;
                            bidx    <= '0;
                            shreg   <= '0;
                            par_acc <= 1'b0;
                            perr_r  <= 1'b0;
                            state   <= rxd ? RX_IDLE : RX_DATA;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (tcnt == LAST) begin
                            tcnt    <= '0;
                            shreg   <= {rxd, shreg[CHAR_W-1:1]};
                            par_acc <= par_acc ^ rxd;
                            if (bidx == nbits - 4'd1) begin
                                state <= cfg_par_en ? RX_PAR : RX_STOP;
                            end else begin
                                bidx <= bidx + 4'd1;
                            end
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    RX_PAR: begin
                        if (tcnt == LAST) begin
                            tcnt   <= '0;
                            perr_r <= (rxd != exp_par);
                            state  <= RX_STOP;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (tcnt == LAST) begin
                            tcnt          <= '0;
                            char_valid    <= 1'b1;
                            char_out.data <= shreg >> (4'(CHAR_W) - nbits);
                            char_out.perr <= cfg_par_en & perr_r;
                            state         <= RX_IDLE;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    // R2: each completion is a single-cycle pulse.
    assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |=> !char_valid);
endmodule

// File: rtl/uart_rx_fifo.sv
// Module: uart_rx_fifo
// Receive queue that keeps characters in arrival order. A write into a full
// queue is refused and reported as an overrun event. Reports when a new
// entry becomes the head, and that entry's parity tag.
// Assumes DEPTH is a power of two.
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_req,
    input  rx_entry_t                  push_data,
    input  logic                       pop_req,
    output rx_entry_t                  head,
    output logic [$clog2(DEPTH):0]     level,
    output logic                       overrun_evt,
    output logic                       head_new_valid,
    output logic                       head_new_perr
);
    localparam int AW = $clog2(DEPTH);

    rx_entry_t     mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          full;
    logic          empty;
    logic          push;
    logic          pop;
    rx_entry_t     next_entry;

    assign full        = (level == (AW+1)'(DEPTH));
    assign empty       = (level == '0);
    assign push        = push_req && !full;
    assign pop         = pop_req && !empty;
    assign overrun_evt = push_req && full;
    assign head        = mem[rd_ptr];
    assign next_entry  = mem[AW'(rd_ptr + 1'b1)];

    // Head change detection: a write into an empty queue, a pop of the last
    // entry with a write in the same cycle, or a pop that exposes the next
    // entry.
    always_comb begin
        head_new_valid = 1'b0;
        head_new_perr  = 1'b0;
        if (push && (empty || (pop && level == (AW+1)'(1)))) begin
            head_new_valid = 1'b1;
            head_new_perr  = push_data.perr;
        end else if (pop && level > (AW+1)'(1)) begin
            head_new_valid = 1'b1;
            head_new_perr  = next_entry.perr;
        end
    end

    // Storage write; no reset is needed for the data.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            level <= level + (AW+1)'(push) - (AW+1)'(pop);
        end
    end

    // R11: occupancy never goes above the depth.
    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        level <= (AW+1)'(DEPTH));
    // R5: a refused write leaves occupancy and the head unchanged.
    assert_full_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full && !pop_req) |=> ($stable(level) && $stable(head)));
endmodule

// File: rtl/uart_rx_status.sv
// Module: uart_rx_status
// Sticky overrun and parity-error flags. An event that sets a flag in the
// same cycle as a status read takes priority over the clear.
module uart_rx_status (
    input  logic clk,
    input  logic rst_n,
    input  logic overrun_evt,
    input  logic head_new_valid,
    input  logic head_new_perr,
    input  logic rd_status,
    output logic ovr,
    output logic pe
);
    logic pe_set;

    assign pe_set = head_new_valid && head_new_perr;

    // Flag update: a set event wins over the clear from a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr <= 1'b0;
            pe  <= 1'b0;
        end else begin
            if (overrun_evt)    ovr <= 1'b1;
            else if (rd_status) ovr <= 1'b0;
            if (pe_set)         pe  <= 1'b1;
            else if (rd_status) pe  <= 1'b0;
        end
    end

    // R6: a discarded completion raises the flag in the next cycle.
    assert_ovr_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_evt |=> ovr);
    // R6: a status read with no new overrun clears the flag.
    assert_ovr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !overrun_evt) |=> !ovr);
    // R8: a tagged character arriving at the head raises the flag.
    assert_pe_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (head_new_valid && head_new_perr) |=> pe);
    // R9: a status read with no tagged arrival clears the flag.
    assert_pe_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !(head_new_valid && head_new_perr)) |=> !pe);
endmodule

// File: rtl/uart_rx_lsr.sv
// Module: uart_rx_lsr
// Top of the serial receive path: frame decoder, receive queue and status
// flags. Assumes rxd is already synchronised to clk and baud_tick runs at
// 16 times the bit rate.
module uart_rx_lsr
    import uart_rx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 16,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              baud_tick,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic [1:0]        cfg_par_sel,
    input  logic              rd_data_strobe,
    input  logic              rd_status_strobe,
    output logic [CHAR_W-1:0] rd_data,
    output logic              st_data_ready,
    output logic              st_overrun,
    output logic              st_parity_err,
    output logic [LW-1:0]     fifo_level
);
    logic      char_valid;
    rx_entry_t char_entry;
    rx_entry_t head;
    logic      overrun_evt;
    logic      head_new_valid;
    logic      head_new_perr;

    uart_rx_deser #(.OSR(OSR)) i_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .rxd        (rxd),
        .baud_tick  (baud_tick),
        .cfg_len    (cfg_len),
        .cfg_par_en (cfg_par_en),
        .cfg_par_sel(cfg_par_sel),
        .char_valid (char_valid),
        .char_out   (char_entry)
    );

    uart_rx_fifo #(.DEPTH(DEPTH)) i_fifo (
        .clk           (clk),
        .rst_n         (rst_n),
        .push_req      (char_valid),
        .push_data     (char_entry),
        .pop_req       (rd_data_strobe),
        .head          (head),
        .level         (fifo_level),
        .overrun_evt   (overrun_evt),
        .head_new_valid(head_new_valid),
        .head_new_perr (head_new_perr)
    );

    uart_rx_status i_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .overrun_evt   (overrun_evt),
        .head_new_valid(head_new_valid),
        .head_new_perr (head_new_perr),
        .rd_status     (rd_status_strobe),
        .ovr           (st_overrun),
        .pe            (st_parity_err)
    );

    assign rd_data       = head.data;
    assign st_data_ready = (fifo_level != '0);

    // R4: removing the last entry with no new arrival drops the ready flag.
    assert_ready_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_strobe && fifo_level == LW'(1) && !char_valid) |=> !st_data_ready);
endmodule

// File: tb/test_uart_rx_lsr.sv
// Scoreboard bench: frame sender tasks queue the expected entries, and the
// pop monitor compares the head character and parity flag as entries leave.
module test_uart_rx_lsr;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       baud_tick = 1'b0;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic [1:0] cfg_par_sel = 2'd0;
    logic       rd_data_strobe = 1'b0;
    logic       rd_status_strobe = 1'b0;
    logic [7:0] rd_data;
    logic       st_data_ready;
    logic       st_overrun;
    logic       st_parity_err;
    logic [4:0] fifo_level;

    int checks = 0;
    int errors = 0;
    logic [8:0] sb [$];
    logic       sending;
    int         ovr_cycles;

    uart_rx_lsr i_uart_rx_lsr (
        .clk             (clk),
        .rst_n           (rst_n),
        .rxd             (rxd),
        .baud_tick       (baud_tick),
        .cfg_len         (cfg_len),
        .cfg_par_en      (cfg_par_en),
        .cfg_par_sel     (cfg_par_sel),
        .rd_data_strobe  (rd_data_strobe),
        .rd_status_strobe(rd_status_strobe),
        .rd_data         (rd_data),
        .st_data_ready   (st_data_ready),
        .st_overrun      (st_overrun),
        .st_parity_err   (st_parity_err),
        .fifo_level      (fifo_level)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Tick generator: one pulse every 4 clocks, driven on falling edges.
    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            baud_tick = (c == 3);
            c = (c + 1) % 4;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hold_bit(input logic v);
        rxd = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    // Driver: send one frame and queue its expected entry.
    task automatic send_frame(input logic [7:0] d, input logic bad_par, input logic expect_queued);
        int n;
        logic [7:0] m;
        logic ones;
        logic pbit;
        n = int'(cfg_len) + 5;
        m = 8'((9'd1 << n) - 9'd1);
        ones = ^(d & m);
        case (cfg_par_sel)
            2'd0:    pbit = ~ones;
            2'd1:    pbit = ones;
            2'd2:    pbit = 1'b1;
            default: pbit = 1'b0;
        endcase
        pbit = pbit ^ bad_par;
        @(negedge clk);
        hold_bit(1'b0);
        for (int i = 0; i < n; i++) hold_bit(d[i]);
        if (cfg_par_en) hold_bit(pbit);
        hold_bit(1'b1);
        repeat (16) @(negedge clk);
        if (expect_queued) sb.push_back({cfg_par_en & bad_par, d & m});
    endtask

    task automatic pulse_status();
        @(negedge clk) rd_status_strobe = 1'b1;
        @(negedge clk) rd_status_strobe = 1'b0;
    endtask

    task automatic pulse_pop();
        @(negedge clk) rd_data_strobe = 1'b1;
        @(negedge clk) rd_data_strobe = 1'b0;
    endtask

    // Monitor: compare the head against the scoreboard, then read status and pop.
    task automatic drain(input string req);
        while (sb.size() > 0) begin
            logic [8:0] e;
            e = sb.pop_front();
            check({req, " R4 ready"}, int'(st_data_ready), 1);
            check({req, " R2 data"}, int'(rd_data), int'(e[7:0]));
            check({req, " R8 head parity flag"}, int'(st_parity_err), int'(e[8]));
            pulse_status();
            if (e[8]) check("R9 parity flag cleared by status read", int'(st_parity_err), 0);
            pulse_pop();
        end
        check({req, " R4 ready after drain"}, int'(st_data_ready), 0);
        check({req, " R11 level after drain"}, int'(fifo_level), 0);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 ready", int'(st_data_ready), 0);
        check("R1 overrun", int'(st_overrun), 0);
        check("R1 parity", int'(st_parity_err), 0);
        check("R1 level", int'(fifo_level), 0);

        // R2: 8-bit characters with no parity
        send_frame(8'hA5, 1'b0, 1'b1);
        send_frame(8'h3C, 1'b0, 1'b1);
        check("R11 level two", int'(fifo_level), 2);
        drain("R2 8N1");

        // R3: short characters are right-aligned
        cfg_len = 2'd0; send_frame(8'hFF, 1'b0, 1'b1);
        cfg_len = 2'd1; send_frame(8'hEA, 1'b0, 1'b1);
        cfg_len = 2'd2; send_frame(8'hD5, 1'b0, 1'b1);
        check("R11 level three", int'(fifo_level), 3);
        drain("R3 lengths");
        cfg_len = 2'd3;

        // R7, R8: parity modes; a tagged character behind a good head
        cfg_par_en = 1'b1;
        cfg_par_sel = 2'd1; send_frame(8'h17, 1'b0, 1'b1);
        cfg_par_sel = 2'd0; send_frame(8'h17, 1'b1, 1'b1);
        check("R8 tagged entry behind good head", int'(st_parity_err), 0);
        cfg_par_sel = 2'd0; send_frame(8'h81, 1'b0, 1'b1);
        cfg_par_sel = 2'd2; send_frame(8'h00, 1'b1, 1'b1);
        cfg_par_sel = 2'd3; send_frame(8'h6E, 1'b0, 1'b1);
        cfg_par_sel = 2'd3; send_frame(8'h5A, 1'b1, 1'b1);
        cfg_par_sel = 2'd2; send_frame(8'h99, 1'b0, 1'b1);
        drain("R7 parity modes");
        cfg_par_en = 1'b0;
        cfg_par_sel = 2'd0;

        // R10: a short low pulse is not a start bit
        @(negedge clk) rxd = 1'b0;
        repeat (12) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * BIT_CLKS) @(negedge clk);
        check("R10 glitch not queued", int'(fifo_level), 0);
        check("R10 ready stays low", int'(st_data_ready), 0);

        // R5, R6: fill the queue, then overflow it while the status strobe is held high
        for (int k = 0; k < 16; k++) send_frame(8'(k * 7 + 1), 1'b0, 1'b1);
        check("R11 level full", int'(fifo_level), 16);
        check("R6 no overrun yet", int'(st_overrun), 0);
        ovr_cycles = 0;
        sending = 1'b1;
        @(negedge clk) rd_status_strobe = 1'b1;
        fork
            begin
                send_frame(8'hEE, 1'b0, 1'b0);
                sending = 1'b0;
            end
            begin
                while (sending) begin
                    @(negedge clk);
                    if (st_overrun) ovr_cycles++;
                end
            end
        join
        rd_status_strobe = 1'b0;
        check("R6 set wins over same-cycle clear", ovr_cycles, 1);
        check("R6 cleared by later status read", int'(st_overrun), 0);
        check("R5 level unchanged", int'(fifo_level), 16);
        send_frame(8'hDD, 1'b0, 1'b0);
        check("R6 overrun sticky", int'(st_overrun), 1);
        pulse_status();
        check("R6 overrun cleared", int'(st_overrun), 0);
        drain("R5 contents kept");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule